// File: doc/BRIEF.md
# Stack-Relative Signed Offset Adder

This block forms a 16-bit address from a stack base and a signed 8-bit displacement. A caller raises a one-cycle start strobe with the current stack value and the displacement byte. One clock later the block returns the wrapped 16-bit sum, a packed status byte and a one-cycle done strobe. The stack value is an input only, and the block never changes it. The sum is meant for the pair register that the surrounding datapath keeps.

The status byte follows the low-byte rule. The displacement's raw byte is added unsigned to the low byte of the stack value. The carry out of bit 3 gives the half-carry bit. The carry out of bit 7 gives the carry bit. The zero and subtract bits are always clear. Because of this, a negative displacement can set both carries even when the 16-bit result is smaller than the base.

Top module: `sp_offset_adder`

## Requirements
- R1: `done` is high for exactly the one cycle after a cycle in which `start` was sampled high. It is low after any cycle in which `start` was sampled low.
- R2: When `done` is high, `sum_out` equals `sp_in` plus `offs_in` sign-extended to 16 bits, taken modulo 2^16, using the inputs sampled with `start`.
- R3: The sum wraps at 16 bits in both directions. For example, 0xFFFF plus 0x0A gives 0x0009, and 0xFF00 plus 0x80 (-128) gives 0xFE80.
- R4: In `flags_out`, bit 7 (zero) and bit 6 (subtract) are always 0 after an operation, including when the sum is 0.
- R5: `flags_out` bit 5 (half-carry) is 1 exactly when `sp_in[3:0]` + `offs_in[3:0]` is greater than 0xF.
- R6: `flags_out` bit 4 (carry) is 1 exactly when `sp_in[7:0]` + `offs_in[7:0]`, added unsigned, is greater than 0xFF. A negative displacement uses its raw two's-complement byte in this sum.
- R7: `flags_out` bits 3..0 are always 0.
- R8: `sum_out` and `flags_out` keep their values across cycles in which `start` is low, whatever `sp_in` and `offs_in` do.
- R9: After reset, `done`, `sum_out` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block |
| start | input | 1 | Strobe that samples the operands |
| sp_in | input | 16 | Stack base value |
| offs_in | input | 8 | Signed displacement byte |
| sum_out | output | 16 | Wrapped sum |
| flags_out | output | 8 | Status byte {Z,N,H,C,0000} |
| done | output | 1 | Result-valid strobe |

## Verification
Each state register drives a port directly, so any wrong internal value shows on the port in the cycle after the start strobe that loaded it. A carry taken from the wrong bit, or from the signed 16-bit result, shows on `flags_out` for vectors whose low-byte carry and 16-bit behaviour disagree. An enable that is missing or stuck shows as `sum_out` or `flags_out` changing while `start` is low, or as a `done` pulse without a start. A broken reset release shows as nonzero outputs in the first idle cycles.

// File: rtl/sof_pkg.sv
package sof_pkg;
  parameter int unsigned BASE_W = 16;
  parameter int unsigned OFFS_W = 8;
  parameter int unsigned FLAG_W = 8;
  localparam int unsigned NIB_W = OFFS_W / 2;

  // Bit positions of the status byte
  localparam int unsigned FZ_BIT = 7;
  localparam int unsigned FN_BIT = 6;
  localparam int unsigned FH_BIT = 5;
  localparam int unsigned FC_BIT = 4;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;
endpackage

// File: rtl/sof_rst_sync.sv
module sof_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sof_core.sv
module sof_core
  import sof_pkg::*;
#(
  parameter int unsigned BW = 16,
  parameter int unsigned OW = 8
) (
  input  logic [BW-1:0] base,
  input  logic [OW-1:0] offs,
  output logic [BW-1:0] sum,
  output flag_t         flg
);
  localparam int unsigned HW = OW / 2;

  logic [BW-1:0] offs_ext;
  logic [HW:0]   nib_sum;
  logic [OW:0]   byte_sum;

  always_comb begin
    offs_ext = {{(BW-OW){offs[OW-1]}}, offs};
    sum      = base + offs_ext;
    nib_sum  = {1'b0, base[HW-1:0]} + {1'b0, offs[HW-1:0]};
    byte_sum = {1'b0, base[OW-1:0]} + {1'b0, offs};
    flg.z    = 1'b0;
    flg.n    = 1'b0;
    flg.h    = nib_sum[HW];
    flg.c    = byte_sum[OW];
  end
endmodule

// File: rtl/sof_out_reg.sv
module sof_out_reg
  import sof_pkg::*;
#(
  parameter int unsigned BW = 16,
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [BW-1:0] sum_d,
  input  flag_t         flg_d,
  output logic [BW-1:0] sum_q,
  output logic [FW-1:0] flags_q,
  output logic          vld_q
);
  logic [BW-1:0] sum_nx;
  logic [FW-1:0] flags_nx, flags_pack;
  logic          vld_nx;

  always_comb begin
    flags_pack         = '0;
    flags_pack[FZ_BIT] = flg_d.z;
    flags_pack[FN_BIT] = flg_d.n;
    flags_pack[FH_BIT] = flg_d.h;
    flags_pack[FC_BIT] = flg_d.c;
    sum_nx   = en ? sum_d : sum_q;
    flags_nx = en ? flags_pack : flags_q;
    vld_nx   = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      flags_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      sum_q   <= sum_nx;
      flags_q <= flags_nx;
      vld_q   <= vld_nx;
    end
  end
endmodule

// File: rtl/sp_offset_adder.sv
module sp_offset_adder
  import sof_pkg::*;
#(
  parameter int unsigned BW = 16,
  parameter int unsigned OW = 8,
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] sp_in,
  input  logic [OW-1:0] offs_in,
  output logic [BW-1:0] sum_out,
  output logic [FW-1:0] flags_out,
  output logic          done
);
  logic          rst_int_n;
  logic [BW-1:0] core_sum;
  flag_t         core_flg;

  sof_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  sof_core #(.BW(BW), .OW(OW)) u_core (
    .base(sp_in), .offs(offs_in), .sum(core_sum), .flg(core_flg)
  );

  sof_out_reg #(.BW(BW), .FW(FW)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .en(start),
    .sum_d(core_sum), .flg_d(core_flg),
    .sum_q(sum_out), .flags_q(flags_out), .vld_q(done)
  );
endmodule

// File: rtl/sof_chk.sv
module sof_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] sp_in,
  input logic [7:0]  offs_in,
  input logic [15:0] sum_out,
  input logic [7:0]  flags_out,
  input logic        done
);
  // R1
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R1
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R2
  sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sum_out == 16'($past(sp_in) + {{8{$past(offs_in[7])}}, $past(offs_in)}));
  // R6
  carry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> flags_out[4] == (({1'b0, $past(sp_in[7:0])} + {1'b0, $past(offs_in)}) > 9'd255));
  // R5
  half_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> flags_out[5] == (({1'b0, $past(sp_in[3:0])} + {1'b0, $past(offs_in[3:0])}) > 5'd15));
  // R4
  zn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[7:6] == 2'b00);
  // R7
  low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[3:0] == 4'h0);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sum_out) && $stable(flags_out));
endmodule

bind sp_offset_adder sof_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sp_in(sp_in), .offs_in(offs_in),
  .sum_out(sum_out), .flags_out(flags_out), .done(done)
);

// File: tb/sim_sp_offset_adder.sv
module sim_sp_offset_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] sp_in = '0;
  logic [7:0]  offs_in = '0;
  logic [15:0] sum_out;
  logic [7:0]  flags_out;
  logic        done;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sp_offset_adder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sp_in(sp_in), .offs_in(offs_in),
    .sum_out(sum_out), .flags_out(flags_out), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One operation; expected values from integer arithmetic.
  task automatic run_op(input int sp, input int off_signed);
    int s, e_sum, h, c, e_flg;
    s = sp + off_signed;
    e_sum = ((s % 65536) + 65536) % 65536;
    h = ((sp & 15) + (off_signed & 15)) > 15;
    c = ((sp & 255) + (off_signed & 255)) > 255;
    e_flg = (h << 5) | (c << 4);
    @(negedge clk);
    sp_in = 16'(sp); offs_in = 8'(off_signed); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 done", int'(done), 1);
    check("R2 R3 sum", int'(sum_out), e_sum);
    check("R4 R5 R6 R7 flags", int'(flags_out), e_flg);
    @(negedge clk);
    check("R1 done drop", int'(done), 0);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 done", int'(done), 0);
    check("R9 sum", int'(sum_out), 0);
    check("R9 flags", int'(flags_out), 0);
  endtask

  task automatic t_hold;
    run_op(16'h0018, -4);
    sp_in = 16'h1234; offs_in = 8'h55;
    repeat (3) @(negedge clk);
    check("R8 sum hold", int'(sum_out), 16'h0014);
    check("R8 flags hold", int'(flags_out), 8'h30);
    check("R8 done idle", int'(done), 0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    sp_in = 16'h000A; offs_in = 8'h0C; start = 1'b1;
    @(negedge clk);
    check("R1 b2b done1", int'(done), 1);
    check("R5 b2b flags1", int'(flags_out), 8'h20);
    sp_in = 16'h00FF; offs_in = 8'h20;
    @(negedge clk);
    start = 1'b0;
    check("R1 b2b done2", int'(done), 1);
    check("R2 b2b sum2", int'(sum_out), 16'h011F);
    check("R6 b2b flags2", int'(flags_out), 8'h10);
  endtask

  initial begin
    t_reset();
    run_op(16'hFF00, 0);
    run_op(16'hFF00, 16);
    run_op(16'hFF00, -5);
    run_op(16'hFF00, 127);
    run_op(16'hFF00, -127);
    run_op(16'hFF00, -128);   // R3
    run_op(16'hFFFF, 10);     // R3 wrap, both carries
    run_op(16'h00FF, 32);     // R6 only
    run_op(16'h00C0, 127);
    run_op(16'h00FF, 1);
    run_op(16'h000A, 12);     // R5 only
    run_op(16'h000F, -1);
    run_op(16'h00FE, -15);    // R6 only, negative
    run_op(16'h0001, -1);     // R4 zero sum keeps Z clear
    t_hold();
    t_back_to_back();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule